// File: doc/BRIEF.md
# Half-Rate to Full-Rate DDR Write Gearbox

This block sits between a memory controller running on a half-rate clock and the double-data-rate output stage of a DRAM interface. Each half-rate cycle the controller presents one word that holds four DQ beats, a matching mask word and a valid flag. The gearbox spreads every word over two full-rate cycles. In each full-rate cycle it gives a high word, for the rising edge, and a low word, for the falling edge.

Alongside the data it generates the DQ output-enable, a DQS pattern with its own output-enable, and per-beat mask bits, all lined up with the same beats. The full-rate clock is phase-locked at exactly twice the half-rate clock, with every second full-rate rising edge on a half-rate rising edge. The clock-domain handoff therefore uses a toggle that marks which half of the word is due, and needs no FIFO.

DQS is framed by one preamble cycle before the first data beat of a burst and one postamble cycle after its last beat.

Top module: `wr_gearbox`

## Requirements
- R1: In the first full-rate cycle of a word, `dq_h` carries `wdata[DQ_W-1:0]` and `dq_l` carries `wdata[2*DQ_W-1:DQ_W]`. In the second cycle, `dq_h` carries `wdata[3*DQ_W-1:2*DQ_W]` and `dq_l` carries `wdata[4*DQ_W-1:3*DQ_W]`.
- R2: A word is captured on a half-rate rising edge E. Its first full-rate cycle begins on the full-rate rising edge two full-rate periods after E, and its second cycle follows directly.
- R3: `dq_oe` is high in exactly the full-rate cycles that carry beats of words whose `wvalid` was high. Back-to-back valid words give an unbroken `dq_oe`.
- R4: `dqs_oe` is high in the full-rate cycle just before each cycle whose `dq_oe` is high (the preamble).
- R5: `dqs_oe` is high in the full-rate cycle just after each cycle whose `dq_oe` is high (the postamble).
- R6: `dqs_pat` is 1 in every cycle that drives data and 0 in every other cycle, including preamble and postamble. `dqs_oe` is high only in data, preamble or postamble cycles.
- R7: Mask bits follow the data beat order. Beat k of the mask is `wmask[(k+1)*DM_W-1:k*DM_W]`, where DM_W = DQ_W/8. Beats 0 and 2 go to `dm_h`, and beats 1 and 3 go to `dm_l`.
- R8: When `wvalid` is low, `wdata` and `wmask` have no effect. `dq_h`, `dq_l`, `dm_h` and `dm_l` are zero in both cycles of that word.
- R9: While `rst` is high, every output is zero.
- R10: A gap of exactly one idle half-rate cycle between two bursts merges the postamble and the preamble, so `dqs_oe` stays high across both idle full-rate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Half-rate clock |
| clk_f | input | 1 | Full-rate clock, twice clk_h, phase-aligned |
| rst | input | 1 | Synchronous reset, active high |
| wvalid | input | 1 | Half-rate word holds burst data |
| wdata | input | 4*DQ_W | Four DQ beats, beat 0 in the lowest bits |
| wmask | input | 4*DM_W | Four mask beats, same order |
| dq_h | output | DQ_W | Rising-edge data |
| dq_l | output | DQ_W | Falling-edge data |
| dm_h | output | DM_W | Rising-edge mask |
| dm_l | output | DM_W | Falling-edge mask |
| dq_oe | output | 1 | DQ output-enable |
| dqs_oe | output | 1 | DQS output-enable |
| dqs_pat | output | 1 | DQS level for the rising half of the cycle; the falling half is always low |

## Verification
The hardest case to reach is a burst boundary with exactly one idle half-rate cycle between two bursts. There, a postamble cycle and a preamble cycle sit side by side, and a wrong enable window shows up as a one-cycle drop in `dqs_oe`. The stimulus sets this up on purpose with single-word bursts and multi-word bursts separated by gaps of one, two and more idle words. It then runs a random valid pattern that feeds nonzero data and mask on idle words, which exercises R8. The scoreboard works out `dqs_oe` for each cycle from the valid flags of the cycles on either side.

// File: rtl/wr_gearbox.sv
module wr_gearbox #(
  parameter int DQ_W = 16,
  localparam int DM_W = DQ_W / 8
) (
  input  logic              clk_h,
  input  logic              clk_f,
  input  logic              rst,
  input  logic              wvalid,
  input  logic [4*DQ_W-1:0] wdata,
  input  logic [4*DM_W-1:0] wmask,
  output logic [DQ_W-1:0]   dq_h,
  output logic [DQ_W-1:0]   dq_l,
  output logic [DM_W-1:0]   dm_h,
  output logic [DM_W-1:0]   dm_l,
  output logic              dq_oe,
  output logic              dqs_oe,
  output logic              dqs_pat
);

  logic              tog_h, tog_q;
  logic              hv;
  logic [4*DQ_W-1:0] hd;
  logic [4*DM_W-1:0] hm;

  always_ff @(posedge clk_h) begin
    if (rst) begin
      tog_h <= 1'b0;
      hv    <= 1'b0;
      hd    <= '0;
      hm    <= '0;
    end else begin
      tog_h <= ~tog_h;
      hv    <= wvalid;
      hd    <= wvalid ? wdata : '0;
      hm    <= wvalid ? wmask : '0;
    end
  end

  logic first;
  assign first = tog_h ^ tog_q;

  logic            s1_v;
  logic [DQ_W-1:0] s1_h, s1_l;
  logic [DM_W-1:0] s1_mh, s1_ml;

  always_ff @(posedge clk_f) begin
    if (rst) begin
      tog_q  <= 1'b0;
      s1_v   <= 1'b0;
      s1_h   <= '0;
      s1_l   <= '0;
      s1_mh  <= '0;
      s1_ml  <= '0;
      dq_h   <= '0;
      dq_l   <= '0;
      dm_h   <= '0;
      dm_l   <= '0;
      dq_oe  <= 1'b0;
      dqs_oe <= 1'b0;
      dqs_pat <= 1'b0;
    end else begin
      tog_q  <= tog_h;
      s1_v   <= hv;
      s1_h   <= first ? hd[DQ_W-1:0]      : hd[3*DQ_W-1:2*DQ_W];
      s1_l   <= first ? hd[2*DQ_W-1:DQ_W] : hd[4*DQ_W-1:3*DQ_W];
      s1_mh  <= first ? hm[DM_W-1:0]      : hm[3*DM_W-1:2*DM_W];
      s1_ml  <= first ? hm[2*DM_W-1:DM_W] : hm[4*DM_W-1:3*DM_W];
      dq_h   <= s1_h;
      dq_l   <= s1_l;
      dm_h   <= s1_mh;
      dm_l   <= s1_ml;
      dq_oe  <= s1_v;
      dqs_pat <= s1_v;
      dqs_oe <= s1_v | hv | dq_oe;
    end
  end

endmodule

module wr_gearbox_chk #(
  parameter int DQ_W = 16,
  localparam int DM_W = DQ_W / 8
) (
  input logic            clk_f,
  input logic            rst,
  input logic [DQ_W-1:0] dq_h,
  input logic [DQ_W-1:0] dq_l,
  input logic [DM_W-1:0] dm_h,
  input logic [DM_W-1:0] dm_l,
  input logic            dq_oe,
  input logic            dqs_oe,
  input logic            dqs_pat
);

  a_r4_preamble: assert property (@(posedge clk_f) disable iff (rst)
    $rose(dq_oe) |-> $past(dqs_oe));

  a_r5_postamble: assert property (@(posedge clk_f) disable iff (rst)
    $fell(dq_oe) |-> dqs_oe);

  a_r6_pat_in_data: assert property (@(posedge clk_f) disable iff (rst)
    dqs_pat |-> dq_oe);

  a_r3_oe_covered: assert property (@(posedge clk_f) disable iff (rst)
    dq_oe |-> dqs_oe);

  a_r6_no_orphan_oe: assert property (@(posedge clk_f) disable iff (rst)
    (dqs_oe && !dq_oe && !$past(dq_oe)) |=> dq_oe);

  a_r8_idle_zero: assert property (@(posedge clk_f) disable iff (rst)
    !dq_oe |-> (dq_h == '0 && dq_l == '0 && dm_h == '0 && dm_l == '0));

endmodule

bind wr_gearbox wr_gearbox_chk #(.DQ_W(DQ_W)) u_chk (.*);

// File: tb/wr_gearbox_tb.sv
module wr_gearbox_tb;
  localparam int TF   = 10;
  localparam int DQ_W = 16;
  localparam int DM_W = DQ_W / 8;

  logic clk_h, clk_f, rst, wvalid;
  logic [4*DQ_W-1:0] wdata;
  logic [4*DM_W-1:0] wmask;
  logic [DQ_W-1:0] dq_h, dq_l;
  logic [DM_W-1:0] dm_h, dm_l;
  logic dq_oe, dqs_oe, dqs_pat;

  wr_gearbox #(.DQ_W(DQ_W)) u_dut (.*);

  typedef struct {
    logic            v;
    logic [DQ_W-1:0] hi, lo;
    logic [DM_W-1:0] mh, ml;
  } slot_t;

  slot_t q[$];
  int checks = 0, fails = 0;
  bit go = 0, done = 0, mon_end = 0;

  initial begin
    clk_f = 0; clk_h = 0;
    forever begin
      #(TF/2); clk_f = 1; clk_h = ~clk_h;
      #(TF/2); clk_f = 0;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic v, logic [4*DQ_W-1:0] d, logic [4*DM_W-1:0] m);
    slot_t a, b;
    wvalid = v; wdata = d; wmask = m;
    a.v = v; b.v = v;
    a.hi = v ? d[DQ_W-1:0] : '0;          a.lo = v ? d[2*DQ_W-1:DQ_W] : '0;
    b.hi = v ? d[3*DQ_W-1:2*DQ_W] : '0;   b.lo = v ? d[4*DQ_W-1:3*DQ_W] : '0;
    a.mh = v ? m[DM_W-1:0] : '0;          a.ml = v ? m[2*DM_W-1:DM_W] : '0;
    b.mh = v ? m[3*DM_W-1:2*DM_W] : '0;   b.ml = v ? m[4*DM_W-1:3*DM_W] : '0;
    q.push_back(a); q.push_back(b);
    @(posedge clk_h); @(negedge clk_f);
  endtask

  function automatic logic [4*DQ_W-1:0] rdat();
    return {$urandom, $urandom};
  endfunction

  // monitor: R1, R2, R3, R4, R5, R6, R7, R8, R10 per full-rate cycle
  initial begin
    logic prev_v;
    slot_t e;
    prev_v = 0;
    wait (go);
    @(posedge clk_h);
    repeat (2) @(negedge clk_f);
    forever begin
      @(negedge clk_f);
      if (q.size() < 2) break;
      e = q.pop_front();
      chk("R1/R2", "dq_h", dq_h, e.hi);
      chk("R1/R2", "dq_l", dq_l, e.lo);
      chk("R7", "dm_h", dm_h, e.mh);
      chk("R7", "dm_l", dm_l, e.ml);
      chk("R3", "dq_oe", dq_oe, e.v);
      chk("R6", "dqs_pat", dqs_pat, e.v);
      chk((!e.v && prev_v && q[0].v) ? "R10" : (!e.v && q[0].v) ? "R4" : "R5",
          "dqs_oe", dqs_oe, e.v | prev_v | q[0].v);
      prev_v = e.v;
    end
    mon_end = 1;
  end

  initial begin
    #(TF * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; wvalid = 0; wdata = '1; wmask = '1;
    repeat (4) @(posedge clk_h);
    @(negedge clk_f);
    // R9: outputs zero under reset
    chk("R9", "dq_h", dq_h, 0);
    chk("R9", "dq_l", dq_l, 0);
    chk("R9", "dm", {dm_h, dm_l}, 0);
    chk("R9", "oe", {dq_oe, dqs_oe, dqs_pat}, 0);
    @(posedge clk_h); @(negedge clk_f);
    rst = 0; wvalid = 0;
    @(posedge clk_h); @(negedge clk_f);
    go = 1;
    send(0, rdat(), '1);
    send(1, 64'h4444_3333_2222_1111, 8'b11_10_01_00);
    send(0, rdat(), 8'hff);
    send(0, '0, '0);
    for (int i = 0; i < 4; i++) send(1, rdat(), 8'($urandom));
    send(0, rdat(), 8'($urandom));   // R10 one-word gap
    send(1, rdat(), 8'($urandom));
    send(1, rdat(), 8'($urandom));
    send(0, rdat(), 8'($urandom));   // R10 again
    send(1, rdat(), 8'($urandom));
    send(0, rdat(), 8'($urandom));
    send(0, rdat(), 8'($urandom));
    for (int i = 0; i < 60; i++) send(1'($urandom), rdat(), 8'($urandom));
    for (int i = 0; i < 4; i++) send(0, rdat(), 8'($urandom));
    done = 1;
    wait (mon_end);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule